// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block collects transfer requests from two external request lines and decides which DMA channel may take the bus next. Requests are gathered over a sampling window that closes on a strobe derived from the bus clock's falling edge. When a window closes, each enabled channel that saw its request line high during that window gets its single pending bit set. A channel that is disabled ignores its request line, and disabling a channel also drops any pending request it held.

While the CPU owns an idle bus, the lowest-numbered pending channel is granted at once. The pending bit of that channel clears in the same cycle its grant appears, so a request arriving during the transfer is held for later. A grant covers exactly one transfer. Once the data mover reports the transfer done, the bus returns to the CPU. No further grant is issued until the CPU reports one completed bus access, so two DMA transfers can never run back to back. Several requests from one channel before it is serviced merge into a single transfer.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, `req_pending` and `dma_grant` are all zero and `cpu_owns_bus` is 1.
- R2: When `sample_strobe` is high at a clock edge, an enabled channel whose `req_in` bit was high in any cycle since the previous strobe edge, or in this cycle, shows `req_pending` = 1 after that edge.
- R3: If both channels are enabled and both requests fall in the same window, both pending bits become 1 after the same edge.
- R4: With the CPU on an idle bus and both channels pending, channel 0 is granted (`dma_grant` = 2'b01) one cycle later.
- R5: `dma_grant` has at most one bit set, and `cpu_owns_bus` is 1 exactly when `dma_grant` is zero.
- R6: A channel's pending bit reads 0 in the first cycle its grant bit reads 1, unless a window closed with its request on that same edge. A request sampled during its transfer sets the bit again.
- R7: A grant lasts until `xfer_done` is seen high at an edge, and `dma_grant` is zero after that edge.
- R8: After a transfer ends, no grant is issued until `cpu_access_done` is seen high at an edge. A pending channel is then granted one cycle after that edge.
- R9: Several requests from one channel before it is granted produce a single grant and a single transfer.
- R10: A request on a channel whose `chan_en` bit is 0 does not set its pending bit. Clearing `chan_en` clears that channel's pending bit at the next edge.
- R11: While the CPU is on an idle bus, a pending enabled channel is granted at the edge after the one that set the pending bit, without waiting for a CPU access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_strobe | input | 1 | Closes the current request sampling window |
| req_in | input | 2 | Active-high request lines, one per channel |
| chan_en | input | 2 | Per-channel enable |
| cpu_access_done | input | 1 | CPU has completed one bus access |
| xfer_done | input | 1 | Data mover has finished the granted transfer |
| dma_grant | output | 2 | One-hot bus grant to a channel |
| cpu_owns_bus | output | 1 | High while the CPU holds the bus |
| req_pending | output | 2 | Pending-request bits, one per channel |

## Verification
The assertions assume that `xfer_done` only means something while a grant is active, and that `cpu_access_done` only means something after a transfer. They ignore these strobes in other phases rather than require them to be absent. The random stimulus asserts `xfer_done` only while `dma_grant` is nonzero. It drives `cpu_access_done`, `sample_strobe`, the request lines and the enables freely, so the arbiter also meets strobes that arrive in phases where they should have no effect.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

    typedef enum logic [1:0] {
        PH_CPU_IDLE = 2'd0,
        PH_DMA_XFER = 2'd1,
        PH_CPU_TURN = 2'd2
    } bus_phase_e;

    typedef struct packed {
        logic start;
        logic finish;
        logic resume;
    } phase_evt_t;

    localparam int unsigned PICK_W = 32;

    function automatic logic [PICK_W-1:0] pick_lowest(input logic [PICK_W-1:0] vec);
        logic [PICK_W-1:0] res;
        logic              found;
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < PICK_W; i++) begin
            if (vec[i] && !found) begin
                res[i] = 1'b1;
                found  = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/dmaarb_chan.sv
module dmaarb_chan (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic sample,
    input  logic en,
    input  logic clr,
    output logic pend
);
    logic seen_q;
    logic seen_now;
    logic set_now;

    assign seen_now = seen_q | req;
    assign set_now  = sample & seen_now & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            seen_q <= sample ? 1'b0 : seen_now;
            pend   <= ((pend & ~clr) | set_now) & en;
        end
    end

    // R10
    disabled_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pend);

    // R6
    grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !sample) |=> !pend);

endmodule

// File: rtl/dmaarb_sched.sv
module dmaarb_sched
    import dmaarb_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend_eff,
    input  logic           xfer_done,
    input  logic           cpu_done,
    output logic [NCH-1:0] grant,
    output logic [NCH-1:0] clr,
    output logic           cpu_owns
);
    bus_phase_e       phase_q;
    bus_phase_e       phase_d;
    phase_evt_t       evt;
    logic [NCH-1:0]   pick;
    logic [PICK_W-1:0] pick_wide;

    assign pick_wide = pick_lowest(PICK_W'(pend_eff));
    assign pick      = pick_wide[NCH-1:0];

    always_comb begin
        evt.start  = (phase_q == PH_CPU_IDLE) && (|pend_eff);
        evt.finish = (phase_q == PH_DMA_XFER) && xfer_done;
        evt.resume = (phase_q == PH_CPU_TURN) && cpu_done;
        phase_d    = phase_q;
        unique case (phase_q)
            PH_CPU_IDLE: if (evt.start)  phase_d = PH_DMA_XFER;
            PH_DMA_XFER: if (evt.finish) phase_d = PH_CPU_TURN;
            PH_CPU_TURN: if (evt.resume) phase_d = PH_CPU_IDLE;
            default:                     phase_d = PH_CPU_IDLE;
        endcase
        clr = evt.start ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_CPU_IDLE;
            grant    <= '0;
            cpu_owns <= 1'b1;
        end else begin
            phase_q <= phase_d;
            if (evt.start) begin
                grant    <= pick;
                cpu_owns <= 1'b0;
            end else if (evt.finish) begin
                grant    <= '0;
                cpu_owns <= 1'b1;
            end
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R4
    ch0_first_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CPU_IDLE && pend_eff[0]) |=> grant[0]);

    // R7
    one_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && xfer_done) |=> (grant == '0));

    // R8
    cpu_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CPU_TURN && !cpu_done) |=> (grant == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sample_strobe,
    input  logic [NCH-1:0] req_in,
    input  logic [NCH-1:0] chan_en,
    input  logic           cpu_access_done,
    input  logic           xfer_done,
    output logic [NCH-1:0] dma_grant,
    output logic           cpu_owns_bus,
    output logic [NCH-1:0] req_pending
);
    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmaarb_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .req    (req_in[c]),
            .sample (sample_strobe),
            .en     (chan_en[c]),
            .clr    (clr[c]),
            .pend   (pend[c])
        );
    end

    dmaarb_sched #(.NCH(NCH)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .pend_eff  (pend & chan_en),
        .xfer_done (xfer_done),
        .cpu_done  (cpu_access_done),
        .grant     (dma_grant),
        .clr       (clr),
        .cpu_owns  (cpu_owns_bus)
    );

    assign req_pending = pend;

    // R5
    owner_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_owns_bus == (dma_grant == '0));

    // R2
    window_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && req_in[0] && chan_en[0] && !clr[0]) |=> req_pending[0]);

endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_strobe = 1'b0;
    logic [1:0] req_in = 2'b00;
    logic [1:0] chan_en = 2'b11;
    logic       cpu_access_done = 1'b0;
    logic       xfer_done = 1'b0;
    logic [1:0] dma_grant;
    logic       cpu_owns_bus;
    logic [1:0] req_pending;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dma_req_arbiter dut (
        .clk(clk), .rst(rst), .sample_strobe(sample_strobe), .req_in(req_in),
        .chan_en(chan_en), .cpu_access_done(cpu_access_done), .xfer_done(xfer_done),
        .dma_grant(dma_grant), .cpu_owns_bus(cpu_owns_bus), .req_pending(req_pending)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: owner -1 = CPU idle, 0/1 = channel, 2 = CPU turn
    int       m_owner = -1;
    bit [1:0] m_pend  = 2'b00;
    bit [1:0] m_seen  = 2'b00;

    always @(posedge clk) begin
        if (rst) begin
            m_owner = -1; m_pend = 2'b00; m_seen = 2'b00;
        end else begin
            bit [1:0] taken;
            bit [1:0] fresh;
            taken = 2'b00;
            if (m_owner == -1) begin
                if (m_pend[0] && chan_en[0]) begin m_owner = 0; taken = 2'b01; end
                else if (m_pend[1] && chan_en[1]) begin m_owner = 1; taken = 2'b10; end
            end else if (m_owner == 2) begin
                if (cpu_access_done) m_owner = -1;
            end else if (xfer_done) begin
                m_owner = 2;
            end
            fresh  = sample_strobe ? ((m_seen | req_in) & chan_en) : 2'b00;
            m_seen = sample_strobe ? 2'b00 : (m_seen | req_in);
            m_pend = ((m_pend & ~taken) | fresh) & chan_en;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int eg;
            eg = (m_owner == 0) ? 1 : (m_owner == 1) ? 2 : 0;
            chk(dma_grant == 2'(eg), "R5 grant vs model", dma_grant, eg);
            chk(req_pending == m_pend, "R2 pending vs model", req_pending, m_pend);
            chk(cpu_owns_bus == (eg == 0), "R8 owner vs model", cpu_owns_bus, eg == 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 during reset
        chk(req_pending == 2'b00, "R1 pending", req_pending, 0);
        chk(dma_grant == 2'b00, "R1 grant", dma_grant, 0);
        chk(cpu_owns_bus == 1'b1, "R1 owner", cpu_owns_bus, 1);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(req_pending == 2'b00 && dma_grant == 2'b00, "R1 after reset", {dma_grant, req_pending}, 0);

        // R2, R3: both requests in one window
        req_in = 2'b11;
        @(negedge clk); req_in = 2'b00; sample_strobe = 1'b1;
        @(negedge clk); sample_strobe = 1'b0;
        chk(req_pending == 2'b11, "R3 both pending", req_pending, 2'b11);
        chk(dma_grant == 2'b00, "R2 not yet granted", dma_grant, 0);
        @(negedge clk);
        // R4, R6, R11
        chk(dma_grant == 2'b01, "R4 ch0 wins", dma_grant, 2'b01);
        chk(req_pending == 2'b10, "R6 cleared on grant", req_pending, 2'b10);
        chk(cpu_owns_bus == 1'b0, "R11 no cpu wait", cpu_owns_bus, 0);
        // R9: ch1 requests again before service
        req_in = 2'b10; sample_strobe = 1'b1;
        @(negedge clk); req_in = 2'b00; sample_strobe = 1'b0; xfer_done = 1'b1;
        chk(req_pending == 2'b10, "R9 collapsed", req_pending, 2'b10);
        @(negedge clk); xfer_done = 1'b0;
        chk(dma_grant == 2'b00, "R7 grant dropped", dma_grant, 0);
        // R6: ch0 re-requests after its grant
        req_in = 2'b01; sample_strobe = 1'b1;
        @(negedge clk); req_in = 2'b00; sample_strobe = 1'b0;
        chk(req_pending == 2'b11, "R6 set again", req_pending, 2'b11);
        repeat (3) @(negedge clk);
        chk(dma_grant == 2'b00, "R8 waits for cpu", dma_grant, 0);
        // R10: disable ch0 together with the CPU access
        chan_en = 2'b10; cpu_access_done = 1'b1;
        @(negedge clk); cpu_access_done = 1'b0;
        chk(req_pending == 2'b10, "R10 disable clears", req_pending, 2'b10);
        @(negedge clk);
        chk(dma_grant == 2'b10, "R8 granted after cpu access", dma_grant, 2'b10);
        chk(req_pending == 2'b00, "R9 single service", req_pending, 0);
        xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0; cpu_access_done = 1'b1;
        @(negedge clk); cpu_access_done = 1'b0;
        // R10: request on disabled channel ignored
        req_in = 2'b01; sample_strobe = 1'b1;
        @(negedge clk); req_in = 2'b00; sample_strobe = 1'b0;
        chk(req_pending == 2'b00, "R10 ignored", req_pending, 0);
        repeat (3) @(negedge clk);
        chk(dma_grant == 2'b00, "R9 no second transfer", dma_grant, 0);

        // Random phase, checked every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            req_in          = 2'($urandom);
            sample_strobe   = ($urandom % 4) == 0;
            if (($urandom % 40) == 0) chan_en = 2'($urandom);
            else if (($urandom % 10) == 0) chan_en = 2'b11;
            xfer_done       = (dma_grant != 2'b00) && ($urandom % 3 == 0);
            cpu_access_done = ($urandom % 3) == 0;
        end
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule